// File: doc/BRIEF.md
# Multidrop Serial Transmitter with Address/Data Tag

This block turns parallel characters into asynchronous serial frames for the master station of a shared multidrop line. Each frame is a low start bit, 5 to 8 data bits sent least significant bit first, one tag bit that marks the character as an address (tag 1) or as data (tag 0), and 1 to 4 high stop bits. The tag fills the slot a parity bit would normally use. No parity is ever computed. Software picks the tag for every character, so the same byte value can go out as an address or as data.

Characters enter over a valid/ready stream port. A transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. The source must hold `in_data`, `tag_sel`, `len_sel` and `stop_sel` stable from the cycle it raises `in_valid` until that transfer. The block captures all four in the transfer cycle, and later changes to them do not affect that character. `in_ready` is the transmitter-ready flag. It is high only while the single holding register is empty and `tx_en` is high.

The holding register hands its character to the frame sequencer when the sequencer is idle and the transmitter is enabled. The bit rate comes from an external `baud_tick` strobe, and every bit lasts 16 strobes. If `tx_en` is cleared during a frame, that frame completes. After it, the line stays high, and a character waiting in the holding register stays there until `tx_en` returns.

Top module: `mdrop_tx`

## Requirements
- R1: After reset, `txd` is 1 and `in_ready` equals `tx_en`.
- R2: `in_ready` is 1 exactly when `tx_en` is 1 and the holding register is empty. The cycle after a transfer, `in_ready` is 0.
- R3: The clock edge that moves a held character into the sequencer drives `txd` to 0 for the start bit.
- R4: After the start bit, the data bits go out LSB first. Their count is 5 + `len_sel` (00→5, 01→6, 10→7, 11→8).
- R5: The bit right after the last data bit equals the `tag_sel` value captured with that character: 1 for an address, 0 for data. No parity is calculated.
- R6: After the tag bit come `stop_sel` + 1 stop bits, all at 1 (00→1 ... 11→4).
- R7: Every bit lasts exactly 16 `baud_tick` pulses. `txd` changes only on the edge after a `baud_tick` or on a load edge.
- R8: Data, tag, length and stop settings are sampled at the transfer. Changing the inputs afterwards has no effect on that frame.
- R9: With `tx_en` at 0, `in_ready` is 0 and nothing loads. A frame already in progress completes, the line then stays at 1, and a held character waits until `tx_en` returns.
- R10: Whenever no frame is in progress, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One-cycle strobe; 16 per bit |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Transmitter ready / holding register empty |
| in_data | input | DATA_W | Character bits, LSB sent first |
| tag_sel | input | 1 | Tag for this character: 1 address, 0 data |
| len_sel | input | LEN_SEL_W | Data length code, length = 5 + code |
| stop_sel | input | STOP_SEL_W | Stop bit code, stops = code + 1 |
| txd | output | 1 | Serial line, idles high |

## Verification
The bench builds the block with its default parameters: 8-bit data, a minimum length of 5, two-bit length and stop codes, and 16 ticks per bit. With these values every data length from 5 to 8 and every stop count from 1 to 4 can be reached. The bench spaces `baud_tick` both every cycle and every third cycle, so the fixed 16-tick bit width is checked independently of the tick spacing. It queues a second character behind a frame in progress, and it drops `tx_en` mid-frame with a character still held. This exercises the enable rule both while a frame is running and while the line is idle.

// File: rtl/mdrop_tx_pkg.sv
package mdrop_tx_pkg;

  typedef enum logic [2:0] {
    LN_IDLE  = 3'd0,
    LN_START = 3'd1,
    LN_DATA  = 3'd2,
    LN_TAG   = 3'd3,
    LN_STOP  = 3'd4
  } line_state_e;

endpackage

// File: rtl/mdrop_tx_hold.sv
module mdrop_tx_hold #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  parameter int STOP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_tag,
  input  logic [IDX_W-1:0]  in_last,
  input  logic [STOP_W-1:0] in_stop,
  input  logic              take,
  output logic              in_ready,
  output logic              full,
  output logic [DATA_W-1:0] h_data,
  output logic              h_tag,
  output logic [IDX_W-1:0]  h_last,
  output logic [STOP_W-1:0] h_stop
);

  logic accept;

  assign in_ready = tx_en & ~full;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      h_data <= '0;
      h_tag  <= 1'b0;
      h_last <= '0;
      h_stop <= '0;
    end else if (accept) begin
      full   <= 1'b1;
      h_data <= in_data;
      h_tag  <= in_tag;
      h_last <= in_last;
      h_stop <= in_stop;
    end else if (take) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/mdrop_tx_baud.sv
module mdrop_tx_baud #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic baud_tick,
  output logic bit_done
);

  localparam int CNT_W = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt;

  assign bit_done = run & baud_tick & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
    end else if (baud_tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mdrop_tx_frame.sv
module mdrop_tx_frame
  import mdrop_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  parameter int STOP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_tag,
  input  logic [IDX_W-1:0]  ld_last,
  input  logic [STOP_W-1:0] ld_stop,
  input  logic              bit_done,
  output logic              idle,
  output logic              txd
);

  line_state_e       st;
  logic [DATA_W-1:0] sh;
  logic              tag_q;
  logic [IDX_W-1:0]  last_q;
  logic [IDX_W-1:0]  dcnt;
  logic [STOP_W-1:0] stop_q;
  logic [STOP_W-1:0] scnt;

  assign idle = (st == LN_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= LN_IDLE;
      sh     <= '0;
      tag_q  <= 1'b0;
      last_q <= '0;
      dcnt   <= '0;
      stop_q <= '0;
      scnt   <= '0;
    end else if (load) begin
      st     <= LN_START;
      sh     <= ld_data;
      tag_q  <= ld_tag;
      last_q <= ld_last;
      stop_q <= ld_stop;
      dcnt   <= '0;
      scnt   <= '0;
    end else if (bit_done) begin
      case (st)
        LN_START: st <= LN_DATA;
        LN_DATA: begin
          sh <= sh >> 1;
          if (dcnt == last_q) st <= LN_TAG;
          else                dcnt <= dcnt + 1'b1;
        end
        LN_TAG: st <= LN_STOP;
        LN_STOP: begin
          if (scnt == stop_q) st <= LN_IDLE;
          else                scnt <= scnt + 1'b1;
        end
        default: st <= LN_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      LN_START: txd = 1'b0;
      LN_DATA:  txd = sh[0];
      LN_TAG:   txd = tag_q;
      default:  txd = 1'b1;
    endcase
  end

endmodule

// File: rtl/mdrop_tx.sv
module mdrop_tx #(
  parameter int DATA_W        = 8,
  parameter int MIN_LEN       = 5,
  parameter int LEN_SEL_W     = 2,
  parameter int STOP_SEL_W    = 2,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_en,
  input  logic                  baud_tick,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DATA_W-1:0]     in_data,
  input  logic                  tag_sel,
  input  logic [LEN_SEL_W-1:0]  len_sel,
  input  logic [STOP_SEL_W-1:0] stop_sel,
  output logic                  txd
);

  localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  logic              hold_full;
  logic [DATA_W-1:0] h_data;
  logic              h_tag;
  logic [IDX_W-1:0]  h_last;
  logic [STOP_SEL_W-1:0] h_stop;
  logic [IDX_W-1:0]  last_idx;
  logic              frame_idle;
  logic              load;
  logic              bit_done;
  int                last_sum;

  // Data length code to index of the final data bit, saturated at DATA_W-1.
  always_comb begin
    last_sum = MIN_LEN - 1 + int'(len_sel);
    if (last_sum > DATA_W - 1) last_sum = DATA_W - 1;
    last_idx = IDX_W'(last_sum);
  end

  assign load = frame_idle & hold_full & tx_en;

  mdrop_tx_hold #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .STOP_W (STOP_SEL_W)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_tag   (tag_sel),
    .in_last  (last_idx),
    .in_stop  (stop_sel),
    .take     (load),
    .in_ready (in_ready),
    .full     (hold_full),
    .h_data   (h_data),
    .h_tag    (h_tag),
    .h_last   (h_last),
    .h_stop   (h_stop)
  );

  mdrop_tx_baud #(
    .TICKS_PER_BIT (TICKS_PER_BIT)
  ) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (~frame_idle),
    .baud_tick (baud_tick),
    .bit_done  (bit_done)
  );

  mdrop_tx_frame #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .STOP_W (STOP_SEL_W)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .ld_data  (h_data),
    .ld_tag   (h_tag),
    .ld_last  (h_last),
    .ld_stop  (h_stop),
    .bit_done (bit_done),
    .idle     (frame_idle),
    .txd      (txd)
  );

endmodule

// File: rtl/mdrop_tx_chk.sv
module mdrop_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic baud_tick,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic load,
  input logic frame_idle
);

  // R2: an accepted character fills the holding register
  p_accept_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9: no readiness while disabled
  p_ready_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !in_ready);

  // R9: no transfer into the sequencer while disabled
  p_load_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> tx_en);

  // R3: start bit follows a load
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);

  // R7: line only moves after a tick or a load
  p_bit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(baud_tick) && !$past(load)) |-> $stable(txd));

  // R10: idle line is high
  p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idle |-> txd);

endmodule

bind mdrop_tx mdrop_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .baud_tick  (baud_tick),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .txd        (txd),
  .load       (load),
  .frame_idle (frame_idle)
);

// File: tb/test_mdrop_tx.sv
`timescale 1ns/1ps
module test_mdrop_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       baud_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       tag_sel = 1'b0;
  logic [1:0] len_sel = '0;
  logic [1:0] stop_sel = '0;
  logic       txd;

  int tests = 0;
  int fails = 0;
  int tick_div = 1;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  logic       m_bits[$];
  int         m_ticks = 0;
  bit         m_full = 0;
  logic [7:0] m_data;
  logic       m_tag;
  int         m_len;
  int         m_stops;
  bit         m_active, m_ld, m_acc;

  always #4 clk = ~clk;

  mdrop_tx i_mdrop_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .baud_tick (baud_tick),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .tag_sel   (tag_sel),
    .len_sel   (len_sel),
    .stop_sel  (stop_sel),
    .txd       (txd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // baud strobe generator
  initial begin
    int tc = 0;
    forever begin
      @(posedge clk); #1;
      tc++;
      if (tc >= tick_div) begin baud_tick = 1'b1; tc = 0; end
      else baud_tick = 1'b0;
    end
  end

  // reference model: frame as a queue of line levels, 16 ticks each
  always @(posedge clk) begin
    if (!rst_n) begin
      m_bits.delete();
      m_ticks = 0;
      m_full = 0;
    end else begin
      m_active = (m_bits.size() != 0);
      m_ld  = !m_active && m_full && tx_en;
      m_acc = in_valid && tx_en && !m_full;
      if (m_active && baud_tick) begin
        m_ticks++;
        if (m_ticks == 16) begin
          void'(m_bits.pop_front());
          m_ticks = 0;
        end
      end
      if (m_ld) begin
        m_bits.push_back(1'b0);
        for (int i = 0; i < m_len; i++) m_bits.push_back(m_data[i]);
        m_bits.push_back(m_tag);
        for (int s = 0; s < m_stops; s++) m_bits.push_back(1'b1);
        m_ticks = 0;
        m_full = 0;
      end
      if (m_acc) begin
        m_full  = 1;
        m_data  = in_data;
        m_tag   = tag_sel;
        m_len   = 5 + int'(len_sel);
        m_stops = 1 + int'(stop_sel);
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(txd === ((m_bits.size() != 0) ? m_bits[0] : 1'b1), cur_req,
            int'(txd), int'((m_bits.size() != 0) ? m_bits[0] : 1'b1), "txd vs model");
      check(in_ready === (tx_en && !m_full), cur_req,
            int'(in_ready), int'(tx_en && !m_full), "in_ready vs model");
    end
  end

  task automatic send(input logic [7:0] d, input logic tg, input logic [1:0] ls, input logic [1:0] ss);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = d; tag_sel = tg; len_sel = ls; stop_sel = ss;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    // R8: scramble settings right after the transfer
    in_valid = 1'b0; in_data = ~d; tag_sel = ~tg; len_sel = 2'(ls + 2'd1); stop_sel = 2'(ss + 2'd2);
  endtask

  task automatic drain();
    forever begin
      @(negedge clk);
      if (m_bits.size() == 0 && !m_full) break;
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(txd === 1'b1, "R1", int'(txd), 1, "reset line level");
    check(in_ready === 1'b0, "R1", int'(in_ready), 0, "reset ready with tx_en low");
    @(posedge clk); #1 tx_en = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R1", int'(in_ready), 1, "ready after enable");

    // R3 R4 R5 R6: 8-bit address character, one stop
    cur_req = "R4";
    send(8'hA5, 1'b1, 2'b11, 2'b00);
    @(negedge clk);
    check(in_ready === 1'b0, "R2", int'(in_ready), 0, "ready drops after transfer");
    drain();
    check(txd === 1'b1, "R10", int'(txd), 1, "line idle after frame");

    // R5: 5-bit data character, two stops
    cur_req = "R5";
    send(8'h5A, 1'b0, 2'b00, 2'b01);
    drain();

    // R6 R7: 6- and 7-bit lengths, 3 and 4 stops, slower ticks
    cur_req = "R7";
    tick_div = 3;
    send(8'h96, 1'b1, 2'b01, 2'b10);
    drain();
    cur_req = "R6";
    send(8'h3F, 1'b0, 2'b10, 2'b11);
    drain();
    tick_div = 1;

    // R2 R8: back-to-back characters, second waits in the holding register
    cur_req = "R2";
    send(8'h81, 1'b1, 2'b11, 2'b00);
    send(8'h7E, 1'b0, 2'b11, 2'b01);
    @(negedge clk);
    check(in_ready === 1'b0, "R2", int'(in_ready), 0, "holding full while frame runs");
    cur_req = "R8";
    drain();

    // R9: disable mid-frame with a character held
    cur_req = "R9";
    send(8'h3C, 1'b1, 2'b11, 2'b00);
    send(8'hC3, 1'b0, 2'b10, 2'b01);
    repeat (30) @(posedge clk);
    #1 tx_en = 1'b0; in_valid = 1'b1; in_data = 8'hFF;
    @(negedge clk);
    check(in_ready === 1'b0, "R9", int'(in_ready), 0, "ready while disabled");
    repeat (400) @(posedge clk);
    @(negedge clk);
    check(txd === 1'b1, "R9", int'(txd), 1, "line idle while disabled");
    check(m_full == 1, "R9", int'(m_full), 1, "held character retained");
    @(posedge clk); #1 in_valid = 1'b0; tx_en = 1'b1;
    drain();
    check(txd === 1'b1, "R10", int'(txd), 1, "idle after resume");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    fails++;
    tests++;
    $display("FAIL watchdog all: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule